// File: doc/BRIEF.md
# Amplifier Mode and Fault Sequencer

This block is the digital timing manager of a two-channel switching power amplifier. It takes a mode request that has already been decoded into standby, mute or operating. It also takes synchronous fault flags from the analog comparators. From these it decides when the output power stage may switch and when the modulator may carry audio. When audio is off, the stage switches at a fixed 50% duty. The block also raises a protection-status flag. Every delay is counted in pulses of a 1 ms tick input, so the clock frequency does not affect the timing.

Start-up runs in two steps: a stage-enable delay, then an audio-enable delay. Before the stage is enabled, the block checks whether an output is shorted to a supply rail. Fault handling depends on the fault type:
- Thermal and supply faults force a complete shutdown and restart a fixed time after the last one clears.
- Current limiting is tolerated for a bounded time.
- A hard short, or limiting that lasts too long, starts a fixed-period off and retry loop.

Top module: `ampseq_sequencer`

## Requirements
- R1: The mode request encoding is 2'b00 standby, 2'b01 mute, 2'b10 operating, and 2'b11 is handled as mute. During and after reset, with standby requested, `stage_en`, `audio_en` and `prot_flag` are low.
- R2: After leaving standby, `stage_en` rises in the clock that samples the START_DLY-th tick (default 100) following the request, provided `rail_short` is low. `audio_en` is low at that moment.
- R3: `audio_en` is high only while `stage_en` is high, the request is operating, and at least AUDIO_DLY ticks (default 50) have been counted since `stage_en` last rose. A direct standby-to-operating request therefore gives audio after 150 ticks.
- R4: An operating request that arrives during mute, before the audio delay has elapsed, does not enable audio early. A return to mute drops `audio_en` while `stage_en` stays high.
- R5: A standby request drops all outputs by the next clock, from any state, and cancels every pending delay. A later request starts from a full START_DLY.
- R6: Whenever a start or restart delay expires while `rail_short` is high, the stage stays off. The stage is enabled in the clock after `rail_short` is first sampled low.
- R7: Any of the four supply or thermal flags (`flt_temp`, `flt_undervolt`, `flt_overvolt`, `flt_unbal`) turns `stage_en` off by the next clock. The stage is enabled again RESTART_DLY ticks (default 100) after the flags clear.
- R8: While `ilim_active` is high, the stage keeps switching and `prot_flag` is high. After OC_TIMEOUT consecutive ticks of limiting (default 10), the stage shuts down.
- R9: A high `hard_short` while the stage runs turns the stage off by the next clock. After an overcurrent shutdown, the stage stays off for exactly RESTART_DLY ticks whatever the flags are, then restarts through the window check. This off and retry loop repeats for as long as the fault recurs.
- R10: `prot_flag` is high only for current limiting while the stage runs, and during overcurrent off time. It stays low during supply, thermal and window-hold shutdowns.
- R11: The mode request code 2'b11 never enables audio, however long it is held.
- R12: When several supply or thermal flags overlap, the restart delay begins only after the last of them has cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-clock pulse every millisecond |
| mode_req | input | 2 | Requested mode (00 standby, 01 mute, 10 operating, 11 mute) |
| flt_temp | input | 1 | Over-temperature flag |
| flt_undervolt | input | 1 | Supply below minimum |
| flt_overvolt | input | 1 | Supply above maximum |
| flt_unbal | input | 1 | Positive and negative supplies out of balance |
| rail_short | input | 1 | An output is shorted to a supply rail (window check) |
| ilim_active | input | 1 | Output current limiting in progress |
| hard_short | input | 1 | Low-impedance short across the load |
| stage_en | output | 1 | Power stage switching enable |
| audio_en | output | 1 | Modulated audio enable (low gives fixed 50% duty) |
| prot_flag | output | 1 | Overcurrent protection status |

## Verification
If a delay counter is off by one or fails to clear, `stage_en` or `audio_en` moves one tick early or late. The bench catches this within a single tick because it samples on both sides of every boundary. A state register stuck in the wrong shutdown class shows up in two ways. `prot_flag` disagrees with the fault that was applied in the very next clock, and the restart edge is missing or misplaced once the off time ends. A wrongly cleared restart timer during overlapping faults shows as an early `stage_en` rise, up to 100 ticks before the expected point.

// File: rtl/ampseq_pkg.sv
package ampseq_pkg;

   typedef enum logic [1:0] {
      MODE_STANDBY = 2'b00,
      MODE_MUTE    = 2'b01,
      MODE_OPER    = 2'b10,
      MODE_ALTMUTE = 2'b11
   } mode_t;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_START  = 3'd1,
      ST_WHOLD  = 3'd2,
      ST_RUN    = 3'd3,
      ST_SUPOFF = 3'd4,
      ST_OCOFF  = 3'd5
   } seq_state_t;

   function automatic logic is_standby(input logic [1:0] m);
      return m == MODE_STANDBY;
   endfunction

   function automatic logic is_oper(input logic [1:0] m);
      return m == MODE_OPER;
   endfunction

endpackage

// File: rtl/ampseq_timer.sv
module ampseq_timer #(
   parameter int LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic tick,
   output logic hit,
   output logic done
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   generate
      if (LIMIT == 1) begin : g_flag
         logic seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               seen_q <= 1'b0;
            else if (clr)             seen_q <= 1'b0;
            else if (en && tick)      seen_q <= 1'b1;
         end
         assign hit  = en && tick && !clr && !seen_q;
         assign done = seen_q;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clr)
               cnt_q <= '0;
            else if (en && tick && (cnt_q != CW'(LIMIT)))
               cnt_q <= cnt_q + 1'b1;
         end
         assign hit  = en && tick && !clr && (cnt_q == CW'(LIMIT - 1));
         assign done = (cnt_q == CW'(LIMIT));
      end
   endgenerate

endmodule

// File: rtl/ampseq_fsm.sv
module ampseq_fsm
   import ampseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_req,
   input  logic       sup_flt,
   input  logic       rail_short,
   input  logic       ilim_active,
   input  logic       hard_short,
   input  logic       start_hit,
   input  logic       rest_hit,
   input  logic       oc_hit,
   output seq_state_t state,
   output logic       start_clr,
   output logic       rest_clr,
   output logic       rest_en,
   output logic       oc_clr
);
   seq_state_t st_q, st_d;
   seq_state_t resume_st;

   assign resume_st = rail_short ? ST_WHOLD : ST_RUN;

   always_comb begin
      st_d = st_q;
      if (is_standby(mode_req)) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:   st_d = ST_START;
            ST_START:  if (sup_flt)                 st_d = ST_SUPOFF;
                       else if (start_hit)          st_d = resume_st;
            ST_WHOLD:  if (sup_flt)                 st_d = ST_SUPOFF;
                       else if (!rail_short)        st_d = ST_RUN;
            ST_RUN:    if (sup_flt)                 st_d = ST_SUPOFF;
                       else if (hard_short || oc_hit) st_d = ST_OCOFF;
            ST_SUPOFF: if (!sup_flt && rest_hit)    st_d = resume_st;
            ST_OCOFF:  if (sup_flt)                 st_d = ST_SUPOFF;
                       else if (rest_hit)           st_d = resume_st;
            default:   st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state     = st_q;
   assign start_clr = (st_q != ST_START);
   assign rest_en   = (st_q == ST_SUPOFF) || (st_q == ST_OCOFF);
   assign rest_clr  = !rest_en || sup_flt;
   assign oc_clr    = (st_q != ST_RUN) || !ilim_active;

endmodule

// File: rtl/ampseq_sequencer.sv
module ampseq_sequencer
   import ampseq_pkg::*;
#(
   parameter int START_DLY   = 100,
   parameter int AUDIO_DLY   = 50,
   parameter int RESTART_DLY = 100,
   parameter int OC_TIMEOUT  = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1ms,
   input  logic [1:0] mode_req,
   input  logic       flt_temp,
   input  logic       flt_undervolt,
   input  logic       flt_overvolt,
   input  logic       flt_unbal,
   input  logic       rail_short,
   input  logic       ilim_active,
   input  logic       hard_short,
   output logic       stage_en,
   output logic       audio_en,
   output logic       prot_flag
);
   localparam int NUM_SUP = 4;

   initial begin
      assert (START_DLY >= 1)   else $error("START_DLY must be at least 1");
      assert (AUDIO_DLY >= 1)   else $error("AUDIO_DLY must be at least 1");
      assert (RESTART_DLY >= 1) else $error("RESTART_DLY must be at least 1");
      assert (OC_TIMEOUT >= 1)  else $error("OC_TIMEOUT must be at least 1");
   end

   logic [NUM_SUP-1:0] sup_vec;
   logic               sup_flt;
   seq_state_t         state;
   logic start_clr, rest_clr, rest_en, oc_clr;
   logic start_hit, rest_hit, oc_hit, audio_done;
   logic start_done_nc, rest_done_nc, oc_done_nc, audio_hit_nc;
   logic in_run;

   assign sup_vec = {flt_unbal, flt_overvolt, flt_undervolt, flt_temp};
   assign sup_flt = |sup_vec;
   assign in_run  = (state == ST_RUN);

   ampseq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_req    (mode_req),
      .sup_flt     (sup_flt),
      .rail_short  (rail_short),
      .ilim_active (ilim_active),
      .hard_short  (hard_short),
      .start_hit   (start_hit),
      .rest_hit    (rest_hit),
      .oc_hit      (oc_hit),
      .state       (state),
      .start_clr   (start_clr),
      .rest_clr    (rest_clr),
      .rest_en     (rest_en),
      .oc_clr      (oc_clr)
   );

   ampseq_timer #(.LIMIT(START_DLY)) u_start_tmr (
      .clk (clk), .rst_n (rst_n), .clr (start_clr), .en (!start_clr),
      .tick (tick_1ms), .hit (start_hit), .done (start_done_nc)
   );

   ampseq_timer #(.LIMIT(RESTART_DLY)) u_rest_tmr (
      .clk (clk), .rst_n (rst_n), .clr (rest_clr), .en (rest_en),
      .tick (tick_1ms), .hit (rest_hit), .done (rest_done_nc)
   );

   ampseq_timer #(.LIMIT(OC_TIMEOUT)) u_oc_tmr (
      .clk (clk), .rst_n (rst_n), .clr (oc_clr), .en (!oc_clr),
      .tick (tick_1ms), .hit (oc_hit), .done (oc_done_nc)
   );

   ampseq_timer #(.LIMIT(AUDIO_DLY)) u_audio_tmr (
      .clk (clk), .rst_n (rst_n), .clr (!in_run), .en (in_run),
      .tick (tick_1ms), .hit (audio_hit_nc), .done (audio_done)
   );

   assign stage_en  = in_run;
   assign audio_en  = in_run && audio_done && is_oper(mode_req);
   assign prot_flag = (in_run && ilim_active) || (state == ST_OCOFF);

endmodule

// File: rtl/ampseq_chk.sv
module ampseq_chk #(
   parameter int AUDIO_DLY = 50
) (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_1ms,
   input logic [1:0] mode_req,
   input logic       flt_temp,
   input logic       flt_undervolt,
   input logic       flt_overvolt,
   input logic       flt_unbal,
   input logic       rail_short,
   input logic       ilim_active,
   input logic       hard_short,
   input logic       stage_en,
   input logic       audio_en,
   input logic       prot_flag
);
   localparam int AW = $clog2(AUDIO_DLY + 1);

   logic [AW-1:0] run_ticks;
   logic          any_sup;

   assign any_sup = flt_temp | flt_undervolt | flt_overvolt | flt_unbal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      run_ticks <= '0;
      else if (!stage_en)                              run_ticks <= '0;
      else if (tick_1ms && run_ticks != AW'(AUDIO_DLY)) run_ticks <= run_ticks + 1'b1;
   end

   p_standby_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req == 2'b00) |=> (!stage_en && !audio_en));

   p_audio_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      audio_en |-> (stage_en && run_ticks == AW'(AUDIO_DLY)));

   p_window_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stage_en) |-> !$past(rail_short));

   p_supply_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (any_sup && stage_en) |=> !stage_en);

   p_hard_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hard_short && stage_en) |=> !stage_en);

   p_prot_scope_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_flag && stage_en) |-> ilim_active);

   p_altmute_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req == 2'b11) |-> !audio_en);

endmodule

bind ampseq_sequencer ampseq_chk #(.AUDIO_DLY(AUDIO_DLY)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tick_1ms      (tick_1ms),
   .mode_req      (mode_req),
   .flt_temp      (flt_temp),
   .flt_undervolt (flt_undervolt),
   .flt_overvolt  (flt_overvolt),
   .flt_unbal     (flt_unbal),
   .rail_short    (rail_short),
   .ilim_active   (ilim_active),
   .hard_short    (hard_short),
   .stage_en      (stage_en),
   .audio_en      (audio_en),
   .prot_flag     (prot_flag)
);

// File: tb/ampseq_sequencer_tb.sv
`timescale 1ns/1ps
module ampseq_sequencer_tb;
   localparam int START_DLY   = 100;
   localparam int AUDIO_DLY   = 50;
   localparam int RESTART_DLY = 100;
   localparam int OC_TIMEOUT  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic [1:0] mode = 2'b00;
   logic f_temp = 0, f_uv = 0, f_ov = 0, f_ub = 0;
   logic rail = 0, ilim = 0, hshort = 0;
   logic stage_en, audio_en, prot_flag;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   ampseq_sequencer #(
      .START_DLY(START_DLY), .AUDIO_DLY(AUDIO_DLY),
      .RESTART_DLY(RESTART_DLY), .OC_TIMEOUT(OC_TIMEOUT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .mode_req(mode),
      .flt_temp(f_temp), .flt_undervolt(f_uv), .flt_overvolt(f_ov), .flt_unbal(f_ub),
      .rail_short(rail), .ilim_active(ilim), .hard_short(hshort),
      .stage_en(stage_en), .audio_en(audio_en), .prot_flag(prot_flag)
   );

   function automatic logic exp_stage(input int k);
      return k >= START_DLY;
   endfunction

   function automatic logic exp_audio(input logic [1:0] m, input int k);
      return (m == 2'b10) && (k >= START_DLY + AUDIO_DLY);
   endfunction

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic chk3(input string req, input logic s, input logic a, input logic p);
      chk(req, "stage_en", stage_en, s);
      chk(req, "audio_en", audio_en, a);
      chk(req, "prot_flag", prot_flag, p);
   endtask

   task automatic do_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic go_standby();
      @(negedge clk) mode = 2'b00;
      @(negedge clk);
      chk3("R5", 1'b0, 1'b0, 1'b0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk3("R1", 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk3("R1", 1'b0, 1'b0, 1'b0);

      // R2 / R3: direct standby-to-operating path
      mode = 2'b10;
      do_ticks(START_DLY - 1);
      chk3("R2", 1'b0, 1'b0, 1'b0);
      do_ticks(1);
      chk3("R2", 1'b1, 1'b0, 1'b0);
      do_ticks(AUDIO_DLY - 1);
      chk3("R3", 1'b1, 1'b0, 1'b0);
      do_ticks(1);
      chk3("R3", 1'b1, 1'b1, 1'b0);
      go_standby();

      // R4: mute start, early operating request, back to mute
      @(negedge clk) mode = 2'b01;
      do_ticks(START_DLY);
      chk3("R4", 1'b1, 1'b0, 1'b0);
      do_ticks(10);
      mode = 2'b10;
      @(negedge clk);
      chk3("R4", 1'b1, 1'b0, 1'b0);
      do_ticks(AUDIO_DLY - 11);
      chk3("R4", 1'b1, 1'b0, 1'b0);
      do_ticks(1);
      chk3("R4", 1'b1, 1'b1, 1'b0);
      mode = 2'b01;
      @(negedge clk);
      chk3("R4", 1'b1, 1'b0, 1'b0);
      mode = 2'b10;
      @(negedge clk);
      chk3("R4", 1'b1, 1'b1, 1'b0);
      go_standby();

      // R5: standby mid-delay cancels the timer
      @(negedge clk) mode = 2'b01;
      do_ticks(60);
      go_standby();
      @(negedge clk) mode = 2'b01;
      do_ticks(START_DLY - 1);
      chk("R5", "stage_en after restart", stage_en, 1'b0);
      do_ticks(1);
      chk("R5", "stage_en full delay", stage_en, 1'b1);
      go_standby();

      // R6: held window fault
      @(negedge clk) begin rail = 1'b1; mode = 2'b01; end
      do_ticks(START_DLY);
      chk3("R6", 1'b0, 1'b0, 1'b0);
      do_ticks(30);
      chk3("R10", 1'b0, 1'b0, 1'b0);
      rail = 1'b0;
      @(negedge clk);
      chk3("R6", 1'b1, 1'b0, 1'b0);

      // R7 / R12: supply faults during mute, overlapping
      f_uv = 1'b1;
      @(negedge clk);
      chk3("R7", 1'b0, 1'b0, 1'b0);
      do_ticks(20);
      f_ov = 1'b1;
      do_ticks(5);
      f_uv = 1'b0;
      do_ticks(RESTART_DLY + 20);
      chk3("R12", 1'b0, 1'b0, 1'b0);
      f_ov = 1'b0;
      do_ticks(RESTART_DLY - 1);
      chk3("R12", 1'b0, 1'b0, 1'b0);
      do_ticks(1);
      chk3("R7", 1'b1, 1'b0, 1'b0);
      f_temp = 1'b1;
      @(negedge clk);
      chk3("R7", 1'b0, 1'b0, 1'b0);
      f_temp = 1'b0;
      do_ticks(RESTART_DLY);
      chk("R7", "stage_en after thermal", stage_en, 1'b1);

      // R8: current limiting below and at the timeout
      ilim = 1'b1;
      @(negedge clk);
      chk3("R8", 1'b1, 1'b0, 1'b1);
      do_ticks(OC_TIMEOUT - 1);
      chk3("R8", 1'b1, 1'b0, 1'b1);
      ilim = 1'b0;
      @(negedge clk);
      chk3("R10", 1'b1, 1'b0, 1'b0);
      ilim = 1'b1;
      do_ticks(OC_TIMEOUT - 1);
      chk("R8", "stage_en before timeout", stage_en, 1'b1);
      do_ticks(1);
      chk3("R8", 1'b0, 1'b0, 1'b1);
      ilim = 1'b0;
      do_ticks(RESTART_DLY - 1);
      chk3("R9", 1'b0, 1'b0, 1'b1);
      do_ticks(1);
      chk3("R9", 1'b1, 1'b0, 1'b0);

      // R9: repeated retry against a hard short
      hshort = 1'b1;
      @(negedge clk);
      chk3("R9", 1'b0, 1'b0, 1'b1);
      for (int c = 0; c < 3; c++) begin
         do_ticks(RESTART_DLY - 1);
         chk3("R9", 1'b0, 1'b0, 1'b1);
         do_ticks(1);
         chk("R9", "stage_en retry", stage_en, 1'b1);
         @(negedge clk);
         chk3("R9", 1'b0, 1'b0, 1'b1);
      end
      hshort = 1'b0;
      do_ticks(RESTART_DLY - 2);
      rail = 1'b1;
      do_ticks(2);
      chk3("R6", 1'b0, 1'b0, 1'b0);
      rail = 1'b0;
      @(negedge clk);
      chk3("R6", 1'b1, 1'b0, 1'b0);
      go_standby();

      // random requests against bench functions (R2, R3, R11)
      void'($urandom(32'h5eed_a11));
      for (int it = 0; it < 24; it++) begin
         logic [1:0] m;
         int k;
         m = 2'($urandom_range(1, 3));
         k = $urandom_range(0, 170);
         if (it == 0) begin m = 2'b11; k = 170; end
         if (it == 1) begin m = 2'b10; k = START_DLY + AUDIO_DLY; end
         @(negedge clk) mode = m;
         @(negedge clk);
         do_ticks(k);
         chk(m == 2'b11 ? "R11" : "R2", "stage_en", stage_en, exp_stage(k));
         chk(m == 2'b11 ? "R11" : "R3", "audio_en", audio_en, exp_audio(m, k));
         go_standby();
      end

      finished = 1;
      summary();
      $finish;
   end

endmodule